// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block owns the privilege-transition state of a processor hart that has machine, supervisor and user levels. When the pipeline raises a trap request (an exception or an interrupt), the block chooses the level that handles it. It records the cause, return address and trap value in that level's register set, pushes the interrupt-enable stack, saves the interrupted privilege, and switches the current privilege. When the pipeline raises a return request for one of the three levels, it pops the matching stack and restores the privilege.

For an exception, the handling level comes from the two exception-delegation masks. An interrupt arrives with its handling level already chosen by the interrupt dispatcher. In both cases the chosen level is never below the level that was running. Every transition also produces a one-cycle pulse that tells the memory system to drop any load-reserved reservation.

The return address for the level named on the return-kind input is presented combinationally. Its low bits are cleared to suit the instruction alignment in force. The trap vector address is computed elsewhere.

Top module: `trap_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the current privilege reads machine (2'b11). The saved-privilege field reads 2'b00. All enable and previous-enable bits, and every cause, epc and tval register, read zero. The cancel pulse is low.
- R2: Privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11. Take an exception with cause c whose bit c is set in `mdeleg_mask` and clear in `sdeleg_mask`, raised at user or supervisor. It is handled at supervisor. With bit c clear in `mdeleg_mask`, it is handled at machine.
- R3: An exception whose cause bit is set in both masks is handled at user level, provided the user-level trap extension is configured.
- R4: If the level selected for a trap is below the current privilege, the trap is handled at the current privilege.
- R5: An interrupt (`trap_is_irq`=1) ignores both masks and is handled at `irq_level`. The floor of R4 still applies.
- R6: A trap taken at machine copies `m_ie` into `m_pie`, clears `m_ie` and writes the old privilege into `m_pp`. It also loads `m_epc` with the trap PC and `m_tval` with the trap value, or zero when `trap_val_ok`=0. `m_cause` gets the interrupt flag in bit XLEN-1 and the zero-extended code in the low bits.
- R7: A trap taken at supervisor copies `s_ie` into `s_pie` and clears `s_ie`. It sets `s_pp` to 1 when coming from supervisor and to 0 when coming from user. It loads `s_cause`, `s_epc` and `s_tval` as in R6.
- R8: A trap taken at user copies `u_ie` into `u_pie`, clears `u_ie`, and loads `u_cause`, `u_epc` and `u_tval` as in R6.
- R9: A machine return (`ret_kind`=2'b11) sets `m_ie` from `m_pie`, sets `m_pie`, moves to the privilege in `m_pp`, and then writes user into `m_pp`.
- R10: A supervisor return (`ret_kind`=2'b01) sets `s_ie` from `s_pie` and sets `s_pie`. It moves to supervisor when `s_pp` is 1 and to user otherwise, then clears `s_pp`.
- R11: A user return (`ret_kind`=2'b00) sets `u_ie` from `u_pie`, sets `u_pie` and leaves the privilege at user.
- R12: `resv_cancel` is high for exactly the one cycle after each trap or return request, and low otherwise.
- R13: `ret_pc` shows the epc of the level named by `ret_kind`. Bit 0 is cleared when `rvc_en`=1, and bits [1:0] are cleared when `rvc_en`=0.
- R14: In a cycle with no request, no state changes, whatever the other request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CAUSE_W | Exception or interrupt code |
| irq_level | input | 2 | Handling privilege chosen for an interrupt |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_val_ok | input | 1 | Trap value is present |
| trap_val | input | XLEN | Trap value |
| ret_req | input | 1 | One-cycle return request |
| ret_kind | input | 2 | Return level: 00 user, 01 supervisor, 11 machine |
| mdeleg_mask | input | 2**CAUSE_W | Exception delegation out of machine |
| sdeleg_mask | input | 2**CAUSE_W | Exception delegation out of supervisor |
| rvc_en | input | 1 | Compressed instructions enabled |
| cur_priv | output | 2 | Current privilege |
| m_ie | output | 1 | Machine interrupt enable |
| m_pie | output | 1 | Machine previous enable |
| m_pp | output | 2 | Machine saved privilege |
| s_ie | output | 1 | Supervisor interrupt enable |
| s_pie | output | 1 | Supervisor previous enable |
| s_pp | output | 1 | Supervisor saved privilege |
| u_ie | output | 1 | User interrupt enable |
| u_pie | output | 1 | User previous enable |
| m_cause | output | XLEN | Machine cause |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine trap value |
| s_cause | output | XLEN | Supervisor cause |
| s_epc | output | XLEN | Supervisor exception PC |
| s_tval | output | XLEN | Supervisor trap value |
| u_cause | output | XLEN | User cause |
| u_epc | output | XLEN | User exception PC |
| u_tval | output | XLEN | User trap value |
| ret_pc | output | XLEN | Aligned return target for `ret_kind` |
| resv_cancel | output | 1 | Reservation-cancel pulse |

## Verification
The checker takes it as given that `trap_req` and `ret_req` are never high in the same cycle. It also assumes that `irq_level` only carries one of the three defined privilege codes. The stimulus respects both conditions: every request is raised for a single cycle through one task that drives either a trap or a return, never both. Interrupt levels are taken only from the three legal codes.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  localparam logic [1:0] PRV_U = 2'b00;
  localparam logic [1:0] PRV_S = 2'b01;
  localparam logic [1:0] PRV_M = 2'b11;

  localparam logic [1:0] RET_U = 2'b00;
  localparam logic [1:0] RET_S = 2'b01;
  localparam logic [1:0] RET_M = 2'b11;

  localparam int unsigned NUM_LVL = 3;

  typedef struct packed {
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       sie;
    logic       spie;
    logic       spp;
    logic       uie;
    logic       upie;
  } ie_stack_t;

endpackage

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_seq_pkg::*;
#(
  parameter int unsigned CAUSE_W = 5,
  parameter bit          HAVE_S  = 1'b1,
  parameter bit          HAVE_U  = 1'b1,
  parameter bit          HAVE_N  = 1'b1,
  localparam int unsigned NCAUSE = 1 << CAUSE_W
) (
  input  logic [1:0]         cur_priv,
  input  logic               is_irq,
  input  logic [1:0]         irq_level,
  input  logic [CAUSE_W-1:0] code,
  input  logic [NCAUSE-1:0]  mdeleg,
  input  logic [NCAUSE-1:0]  sdeleg,
  output logic [1:0]         tgt_priv
);

  logic to_sup;
  logic to_usr;
  logic [1:0] raw_priv;

  assign to_sup = mdeleg[code];

  generate
    if (HAVE_S) begin : g_chain3
      assign to_usr = to_sup & HAVE_N & sdeleg[code];
    end else begin : g_chain2
      assign to_usr = to_sup & HAVE_N;
    end
  endgenerate

  always_comb begin
    if (is_irq)                raw_priv = irq_level;
    else if (HAVE_U && to_usr) raw_priv = PRV_U;
    else if (HAVE_S && to_sup) raw_priv = PRV_S;
    else                       raw_priv = PRV_M;
    tgt_priv = (raw_priv < cur_priv) ? cur_priv : raw_priv;
  end

endmodule

// File: rtl/trap_level_regs.sv
module trap_level_regs #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] epc_in,
  input  logic [XLEN-1:0] tval_in,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] tval_q
);

  logic [XLEN-1:0] cause_d, epc_d, tval_d;

  always_comb begin
    cause_d = cause_q;
    epc_d   = epc_q;
    tval_d  = tval_q;
    if (load) begin
      cause_d = cause_in;
      epc_d   = epc_in;
      tval_d  = tval_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      tval_q  <= '0;
    end else if (load) begin
      cause_q <= cause_d;
      epc_q   <= epc_d;
      tval_q  <= tval_d;
    end
  end

endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack
  import trap_seq_pkg::*;
#(
  parameter bit HAVE_U = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_fire,
  input  logic [1:0] tgt_priv,
  input  logic       ret_fire,
  input  logic [1:0] ret_kind,
  output logic [1:0] priv_q,
  output ie_stack_t  stk_q
);

  localparam logic [1:0] MPP_AFTER_RET = HAVE_U ? PRV_U : PRV_M;

  logic [1:0] priv_d;
  ie_stack_t  stk_d;
  logic       upd;

  assign upd = trap_fire | ret_fire;

  always_comb begin
    priv_d = priv_q;
    stk_d  = stk_q;
    if (trap_fire) begin
      priv_d = tgt_priv;
      unique case (tgt_priv)
        PRV_M: begin
          stk_d.mpie = stk_q.mie;
          stk_d.mie  = 1'b0;
          stk_d.mpp  = priv_q;
        end
        PRV_S: begin
          stk_d.spie = stk_q.sie;
          stk_d.sie  = 1'b0;
          stk_d.spp  = (priv_q == PRV_S);
        end
        default: begin
          stk_d.upie = stk_q.uie;
          stk_d.uie  = 1'b0;
        end
      endcase
    end else if (ret_fire) begin
      unique case (ret_kind)
        RET_M: begin
          stk_d.mie  = stk_q.mpie;
          stk_d.mpie = 1'b1;
          priv_d     = stk_q.mpp;
          stk_d.mpp  = MPP_AFTER_RET;
        end
        RET_S: begin
          stk_d.sie  = stk_q.spie;
          stk_d.spie = 1'b1;
          priv_d     = stk_q.spp ? PRV_S : PRV_U;
          stk_d.spp  = 1'b0;
        end
        default: begin
          stk_d.uie  = stk_q.upie;
          stk_d.upie = 1'b1;
          priv_d     = PRV_U;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= PRV_M;
      stk_q  <= '0;
    end else if (upd) begin
      priv_q <= priv_d;
      stk_q  <= stk_d;
    end
  end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_seq_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5,
  parameter bit          HAVE_S  = 1'b1,
  parameter bit          HAVE_U  = 1'b1,
  parameter bit          HAVE_N  = 1'b1,
  localparam int unsigned NCAUSE = 1 << CAUSE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_code,
  input  logic [1:0]         irq_level,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               trap_val_ok,
  input  logic [XLEN-1:0]    trap_val,
  input  logic               ret_req,
  input  logic [1:0]         ret_kind,
  input  logic [NCAUSE-1:0]  mdeleg_mask,
  input  logic [NCAUSE-1:0]  sdeleg_mask,
  input  logic               rvc_en,
  output logic [1:0]         cur_priv,
  output logic               m_ie,
  output logic               m_pie,
  output logic [1:0]         m_pp,
  output logic               s_ie,
  output logic               s_pie,
  output logic               s_pp,
  output logic               u_ie,
  output logic               u_pie,
  output logic [XLEN-1:0]    m_cause,
  output logic [XLEN-1:0]    m_epc,
  output logic [XLEN-1:0]    m_tval,
  output logic [XLEN-1:0]    s_cause,
  output logic [XLEN-1:0]    s_epc,
  output logic [XLEN-1:0]    s_tval,
  output logic [XLEN-1:0]    u_cause,
  output logic [XLEN-1:0]    u_epc,
  output logic [XLEN-1:0]    u_tval,
  output logic [XLEN-1:0]    ret_pc,
  output logic               resv_cancel
);

  localparam int unsigned PAD_W = XLEN - 1 - CAUSE_W;

  logic [1:0]      tgt_priv;
  ie_stack_t       stk;
  logic [XLEN-1:0] cause_in, tval_in;
  logic [XLEN-1:0] lvl_cause [NUM_LVL];
  logic [XLEN-1:0] lvl_epc   [NUM_LVL];
  logic [XLEN-1:0] lvl_tval  [NUM_LVL];
  logic [XLEN-1:0] sel_epc, align_mask;
  logic            cancel_d;

  trap_target_sel #(
    .CAUSE_W(CAUSE_W), .HAVE_S(HAVE_S), .HAVE_U(HAVE_U), .HAVE_N(HAVE_N)
  ) u_sel (
    .cur_priv (cur_priv),
    .is_irq   (trap_is_irq),
    .irq_level(irq_level),
    .code     (trap_code),
    .mdeleg   (mdeleg_mask),
    .sdeleg   (sdeleg_mask),
    .tgt_priv (tgt_priv)
  );

  trap_status_stack #(.HAVE_U(HAVE_U)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_fire(trap_req),
    .tgt_priv (tgt_priv),
    .ret_fire (ret_req),
    .ret_kind (ret_kind),
    .priv_q   (cur_priv),
    .stk_q    (stk)
  );

  assign cause_in = {trap_is_irq, {PAD_W{1'b0}}, trap_code};
  assign tval_in  = trap_val_ok ? trap_val : '0;

  // index 0 user, 1 supervisor, 2 machine
  generate
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      localparam logic [1:0] LVL_CODE = (g == 2) ? PRV_M : 2'(g);
      trap_level_regs #(.XLEN(XLEN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (trap_req && (tgt_priv == LVL_CODE)),
        .cause_in(cause_in),
        .epc_in  (trap_pc),
        .tval_in (tval_in),
        .cause_q (lvl_cause[g]),
        .epc_q   (lvl_epc[g]),
        .tval_q  (lvl_tval[g])
      );
    end
  endgenerate

  assign {u_cause, u_epc, u_tval} = {lvl_cause[0], lvl_epc[0], lvl_tval[0]};
  assign {s_cause, s_epc, s_tval} = {lvl_cause[1], lvl_epc[1], lvl_tval[1]};
  assign {m_cause, m_epc, m_tval} = {lvl_cause[2], lvl_epc[2], lvl_tval[2]};

  assign m_ie  = stk.mie;
  assign m_pie = stk.mpie;
  assign m_pp  = stk.mpp;
  assign s_ie  = stk.sie;
  assign s_pie = stk.spie;
  assign s_pp  = stk.spp;
  assign u_ie  = stk.uie;
  assign u_pie = stk.upie;

  always_comb begin
    unique case (ret_kind)
      RET_M:   sel_epc = lvl_epc[2];
      RET_S:   sel_epc = lvl_epc[1];
      default: sel_epc = lvl_epc[0];
    endcase
    align_mask = rvc_en ? ~XLEN'(1) : ~XLEN'(3);
    ret_pc     = sel_epc & align_mask;
  end

  assign cancel_d = trap_req | ret_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resv_cancel <= 1'b0;
    else        resv_cancel <= cancel_d;
  end

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk
  import trap_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            trap_is_irq,
  input logic [1:0]      irq_level,
  input logic            ret_req,
  input logic [1:0]      ret_kind,
  input logic            rvc_en,
  input logic [1:0]      cur_priv,
  input logic            m_ie,
  input logic            m_pie,
  input logic [1:0]      m_pp,
  input logic            s_ie,
  input logic            s_pie,
  input logic            s_pp,
  input logic [XLEN-1:0] m_epc,
  input logic [XLEN-1:0] s_epc,
  input logic [XLEN-1:0] ret_pc,
  input logic            resv_cancel
);

  // input assumption: requests never overlap (R14)
  assert_req_exclusive_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && ret_req));

  // input assumption: interrupt level is a legal code (R5)
  assert_irq_level_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_is_irq) |-> (irq_level != 2'b10));

  assert_floor_machine_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == PRV_M) |=> (cur_priv == PRV_M));

  assert_floor_super_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == PRV_S) |=> (cur_priv != PRV_U));

  assert_m_entry_stack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == PRV_M) |=>
      (!m_ie && m_pie == $past(m_ie) && m_pp == PRV_M));

  assert_s_entry_stack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == PRV_S) |=>
      (cur_priv == PRV_M || (!s_ie && s_pie == $past(s_ie) && s_pp)));

  assert_mret_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_kind == RET_M) |=>
      (m_pie && m_ie == $past(m_pie) && cur_priv == $past(m_pp) && m_pp == PRV_U));

  assert_sret_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_kind == RET_S) |=>
      (s_pie && !s_pp && s_ie == $past(s_pie) &&
       cur_priv == ($past(s_pp) ? PRV_S : PRV_U)));

  assert_uret_priv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_kind == RET_U) |=> (cur_priv == PRV_U));

  assert_cancel_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req || ret_req) |=> resv_cancel);

  assert_cancel_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req || ret_req) |=> !resv_cancel);

  assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req || ret_req) |=>
      ($stable(cur_priv) && $stable(m_epc) && $stable(s_epc) && $stable(m_pp)));

  always_comb begin
    if (rst_n) begin
      assert_ret_align_R13: assert (rvc_en ? !ret_pc[0] : (ret_pc[1:0] == 2'b00));
    end
  end

endmodule

bind trap_sequencer trap_sequencer_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
  .irq_level(irq_level), .ret_req(ret_req), .ret_kind(ret_kind), .rvc_en(rvc_en),
  .cur_priv(cur_priv), .m_ie(m_ie), .m_pie(m_pie), .m_pp(m_pp), .s_ie(s_ie),
  .s_pie(s_pie), .s_pp(s_pp), .m_epc(m_epc), .s_epc(s_epc), .ret_pc(ret_pc),
  .resv_cancel(resv_cancel)
);

// File: tb/tb_trap_sequencer.sv
`timescale 1ns/1ps
module tb_trap_sequencer;

  localparam int XLEN = 32;
  localparam int CW   = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic trap_req, trap_is_irq, trap_val_ok, ret_req, rvc_en;
  logic [CW-1:0] trap_code;
  logic [1:0] irq_level, ret_kind;
  logic [XLEN-1:0] trap_pc, trap_val;
  logic [31:0] mdeleg_mask, sdeleg_mask;
  logic [1:0] cur_priv, m_pp;
  logic m_ie, m_pie, s_ie, s_pie, s_pp, u_ie, u_pie, resv_cancel;
  logic [XLEN-1:0] m_cause, m_epc, m_tval, s_cause, s_epc, s_tval;
  logic [XLEN-1:0] u_cause, u_epc, u_tval, ret_pc;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  trap_sequencer dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
    .trap_code(trap_code), .irq_level(irq_level), .trap_pc(trap_pc),
    .trap_val_ok(trap_val_ok), .trap_val(trap_val), .ret_req(ret_req),
    .ret_kind(ret_kind), .mdeleg_mask(mdeleg_mask), .sdeleg_mask(sdeleg_mask),
    .rvc_en(rvc_en), .cur_priv(cur_priv), .m_ie(m_ie), .m_pie(m_pie), .m_pp(m_pp),
    .s_ie(s_ie), .s_pie(s_pie), .s_pp(s_pp), .u_ie(u_ie), .u_pie(u_pie),
    .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval), .s_cause(s_cause),
    .s_epc(s_epc), .s_tval(s_tval), .u_cause(u_cause), .u_epc(u_epc),
    .u_tval(u_tval), .ret_pc(ret_pc), .resv_cancel(resv_cancel)
  );

  // op: 0 exception, 1 interrupt, 2 return; sel: irq level or return kind
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  code;
    logic [1:0]  sel;
    logic [31:0] pc;
    logic [1:0]  exp_priv;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 5'd0, 2'b11, 32'h0,      2'b00},
    '{2'd0, 5'd8, 2'b00, 32'h1000,   2'b00},
    '{2'd0, 5'd3, 2'b00, 32'h2000,   2'b01},
    '{2'd0, 5'd8, 2'b00, 32'h3000,   2'b01},
    '{2'd0, 5'd2, 2'b00, 32'h4000,   2'b11},
    '{2'd0, 5'd3, 2'b00, 32'h5000,   2'b11},
    '{2'd2, 5'd0, 2'b11, 32'h0,      2'b11},
    '{2'd2, 5'd0, 2'b11, 32'h0,      2'b00},
    '{2'd1, 5'd5, 2'b01, 32'h6000,   2'b01},
    '{2'd2, 5'd0, 2'b01, 32'h0,      2'b00},
    '{2'd2, 5'd0, 2'b00, 32'h0,      2'b00},
    '{2'd1, 5'd7, 2'b11, 32'h7000,   2'b11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic request(input logic [1:0] op, input logic [4:0] code,
                         input logic [1:0] sel, input logic [31:0] pc,
                         input logic vok, input logic [31:0] val);
    @(negedge clk);
    trap_req    = (op != 2'd2);
    trap_is_irq = (op == 2'd1);
    ret_req     = (op == 2'd2);
    trap_code   = code;
    irq_level   = (op == 2'd1) ? sel : 2'b11;
    ret_kind    = sel;
    trap_pc     = pc;
    trap_val_ok = vok;
    trap_val    = val;
    @(negedge clk);
    trap_req = 1'b0;
    ret_req  = 1'b0;
  endtask

  function automatic logic [31:0] epc_of(input logic [1:0] p);
    case (p)
      2'b11:   return m_epc;
      2'b01:   return s_epc;
      default: return u_epc;
    endcase
  endfunction

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    trap_req = 1'b0; ret_req = 1'b0; trap_is_irq = 1'b0; trap_val_ok = 1'b0;
    trap_code = '0; irq_level = 2'b11; ret_kind = 2'b00; trap_pc = '0; trap_val = '0;
    mdeleg_mask = 32'h0000_0108;
    sdeleg_mask = 32'h0000_0100;
    rvc_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 priv in reset", {30'd0, cur_priv}, 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 priv", {30'd0, cur_priv}, 32'd3);
    check("R1 stack", {23'd0, m_ie, m_pie, m_pp, s_ie, s_pie, s_pp, u_ie, u_pie}, 32'd0);
    check("R1 regs", m_cause | m_epc | m_tval | s_cause | s_epc | s_tval | u_cause | u_epc | u_tval, 32'd0);
    check("R1 cancel", {31'd0, resv_cancel}, 32'd0);

    // table walk: delegation (R2, R3), floor (R4), interrupts (R5), returns
    for (int i = 0; i < NVEC; i++) begin
      request(VECS[i].op, VECS[i].code, VECS[i].sel, VECS[i].pc, 1'b0, 32'h0);
      check($sformatf("R2/R3/R4/R5 vec %0d priv", i), {30'd0, cur_priv}, {30'd0, VECS[i].exp_priv});
      check($sformatf("R12 vec %0d cancel", i), {31'd0, resv_cancel}, 32'd1);
      if (VECS[i].op != 2'd2)
        check($sformatf("R6/R7/R8 vec %0d epc", i), epc_of(VECS[i].exp_priv), VECS[i].pc);
    end

    // machine entry by interrupt code 7 from user
    check("R6 mcause", m_cause, 32'h8000_0007);
    check("R6 mtval zero", m_tval, 32'h0);
    check("R6 stack", {29'd0, m_ie, m_pie, m_pp}, {29'd0, 1'b0, 1'b1, 2'b00});

    request(2'd2, 5'd0, 2'b11, 32'h0, 1'b0, 32'h0);
    check("R9 priv", {30'd0, cur_priv}, 32'd0);
    check("R9 stack", {29'd0, m_ie, m_pie, m_pp}, {29'd0, 1'b1, 1'b1, 2'b00});

    request(2'd0, 5'd3, 2'b00, 32'h8000, 1'b0, 32'h0);
    request(2'd2, 5'd0, 2'b01, 32'h0, 1'b0, 32'h0);
    request(2'd2, 5'd0, 2'b01, 32'h0, 1'b0, 32'h0);
    check("R10 priv", {30'd0, cur_priv}, 32'd0);
    check("R10 stack", {29'd0, s_ie, s_pie, s_pp}, {29'd0, 1'b1, 1'b1, 1'b0});

    request(2'd0, 5'd3, 2'b00, 32'h8003, 1'b1, 32'hDEAD_BEEF);
    check("R7 priv", {30'd0, cur_priv}, 32'd1);
    check("R7 stack", {29'd0, s_ie, s_pie, s_pp}, {29'd0, 1'b0, 1'b1, 1'b0});
    check("R7 stval", s_tval, 32'hDEAD_BEEF);
    check("R7 scause", s_cause, 32'h3);
    check("R7 sepc", s_epc, 32'h8003);
    check("R12 pulse high", {31'd0, resv_cancel}, 32'd1);

    // idle cycle with noise on the non-strobe inputs
    trap_code = 5'd2; trap_pc = 32'hFFFF_FFF0; trap_is_irq = 1'b1;
    @(negedge clk);
    check("R12 pulse ends", {31'd0, resv_cancel}, 32'd0);
    check("R14 priv held", {30'd0, cur_priv}, 32'd1);
    check("R14 sepc held", s_epc, 32'h8003);
    trap_is_irq = 1'b0;

    ret_kind = 2'b01; rvc_en = 1'b1; #1;
    check("R13 rvc align", ret_pc, 32'h8002);
    rvc_en = 1'b0; #1;
    check("R13 word align", ret_pc, 32'h8000);
    ret_kind = 2'b11; #1;
    check("R13 select m", ret_pc, 32'h7000);
    rvc_en = 1'b1;

    request(2'd2, 5'd0, 2'b01, 32'h0, 1'b0, 32'h0);
    request(2'd2, 5'd0, 2'b00, 32'h0, 1'b0, 32'h0);
    check("R11 priv", {30'd0, cur_priv}, 32'd0);
    check("R11 stack", {30'd0, u_ie, u_pie}, 32'd3);

    request(2'd0, 5'd8, 2'b00, 32'h9000, 1'b0, 32'h0);
    check("R8 priv", {30'd0, cur_priv}, 32'd0);
    check("R8 stack", {30'd0, u_ie, u_pie}, 32'd1);
    check("R8 ucause", u_cause, 32'h8);
    check("R8 uepc", u_epc, 32'h9000);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset priv", {30'd0, cur_priv}, 32'd3);
    check("R1 async reset epc", m_epc | s_epc | u_epc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule